// File: doc/BRIEF.md
# Time-Triggered CAN Window Scheduler

This block is the time-triggered scheduling engine of one CAN node. After the first reference message it runs a local cycle-time counter. A programmable prescaler advances that counter, and every later reference message sets it back to zero. A small trigger table describes the basic cycle. Each entry has a time mark, a window type, a direction, a message-object number, a base cycle and a repeat interval. The block walks the entries in table order. When the counter reaches the mark of the current entry, and the entry is due in the present basic cycle, the block sends a one-cycle strobe to the CAN controller. For a transmit entry this is a send request. For a receive entry it opens a reception check.

The block also counts basic cycles inside a system matrix whose length is a power of two. It flags receive entries whose message did not arrive before the next time mark. It raises a watchdog when the cycle time runs out before a new reference message arrives. Every send request is single-shot: the controller must not retry a frame started by this block, in either an exclusive or an arbitrating window. All pins are plain control and status signals. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `ttcan_window_sched`

## Requirements
- R1: The cycle time stays at 0 until the first `ref_rx` pulse. A `ref_rx` pulse sets it to 0, and it then advances by one every `presc_div`+1 clocks. After the clock edge that captures `ref_rx`, the value shown on `cyc_time` k cycles later is k/(`presc_div`+1), rounded down.
- R2: Each entry e occupies `cfg_table[e*27 +: 27]`, laid out as follows: bits [15:0] time mark (at least 1, strictly ascending from entry 0); [17:16] window type (0 exclusive, 1 arbitrating, 2 or 3 free); [18] direction (1 transmit, 0 receive); [21:19] object number; [24:22] base cycle; [26:25] log2 of the repeat interval. A due, non-free transmit entry gives one `tx_req` pulse in the cycle in which `cyc_time` first equals its mark.
- R3: A due, non-free receive entry gives one `rx_chk` pulse at its mark, timed as in R2. Along with either strobe, `trig_obj` carries the entry's object number.
- R4: A free entry produces no strobe. Its mark is still consumed, and it still counts as a time mark for R8. Along with a strobe, `trig_arb` is 1 for an arbitrating window and 0 for an exclusive one.
- R5: An entry is due in basic cycle c when the low r bits of c equal the low r bits of its base cycle, where r is the entry's repeat log2. An entry that is not due produces no strobe.
- R6: The first `ref_rx` after reset sets `cyc_idx` to 0. Every later one increments `cyc_idx` modulo 2^`mat_len_log2`.
- R7: At most one entry fires per timebase tick, in table order. `tx_req` and `rx_chk` are never high together, and each strobe appears only in a cycle in which `cyc_time` has just changed.
- R8: When a receive entry fires, the block waits for a `rx_done` pulse whose `rx_obj` matches the entry. If none arrives by the next time mark or the next `ref_rx`, bit e of `miss_err` is set. The bit is cleared when a later check of that entry receives its message.
- R9: If the cycle time would pass 65535, it holds at 65535 and `wdog` is set. `wdog` then stays set until reset and blocks every `tx_req`. Receive checks carry on.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_div | input | 8 | Timebase divider minus one |
| mat_len_log2 | input | 2 | log2 of basic cycles per matrix |
| cfg_table | input | 108 | Four packed trigger entries |
| ref_rx | input | 1 | Valid reference message received (pulse) |
| rx_done | input | 1 | A message was received (pulse) |
| rx_obj | input | 3 | Object number of the received message |
| tx_req | output | 1 | Single-shot transmit request strobe |
| rx_chk | output | 1 | Reception-check strobe |
| trig_obj | output | 3 | Object number of the fired entry |
| trig_arb | output | 1 | Fired entry lies in an arbitrating window |
| cyc_idx | output | 3 | Basic-cycle index in the matrix |
| cyc_time | output | 16 | Local cycle time |
| wdog | output | 1 | Cycle-time overrun (sticky) |
| miss_err | output | 4 | Per-entry missing-message flags |

## Verification
Every result is registered exactly once. The bench therefore counts k, the number of clock edges since the edge that captured `ref_rx`, and predicts each output as a function of k. A strobe for mark m is due at k = m·(`presc_div`+1). `cyc_time` is due to read k/(`presc_div`+1). A miss flag rises at the same k as the strobe of the next entry, and `cyc_idx` takes its new value at k = 0. The bench drives inputs and samples outputs on the falling edge, checks every cycle of each basic cycle against these formulas, and runs the watchdog case up to the edge at k = 65536, where the flag is due.

// File: rtl/ttsched_pkg.sv
package ttsched_pkg;
  typedef enum logic [1:0] {
    WIN_EXCL  = 2'd0,
    WIN_ARB   = 2'd1,
    WIN_FREE  = 2'd2,
    WIN_FREE3 = 2'd3
  } win_e;

  localparam int REP_W = 2;

  function automatic logic win_is_free(input logic [1:0] t);
    return t[1];
  endfunction
endpackage

// File: rtl/tt_timebase.sv
module tt_timebase #(
  parameter int TIME_W  = 16,
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [PRESC_W-1:0] presc_div,
  output logic [TIME_W-1:0]  ctime,
  output logic [TIME_W-1:0]  next_time,
  output logic               adv,
  output logic               wdog
);
  logic [PRESC_W-1:0] pre_q;
  logic tick, at_max;

  assign tick      = run && !restart && (pre_q == presc_div);
  assign at_max    = &ctime;
  assign adv       = tick && !at_max;
  assign next_time = ctime + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      ctime <= '0;
      wdog  <= 1'b0;
    end else if (restart) begin
      pre_q <= '0;
      ctime <= '0;
    end else if (run) begin
      if (tick) begin
        pre_q <= '0;
        if (at_max) wdog  <= 1'b1;
        else        ctime <= next_time;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tt_cycle_ctr.sv
module tt_cycle_ctr #(
  parameter int CYC_W = 3,
  localparam int LEN_W = $clog2(CYC_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rx,
  input  logic [LEN_W-1:0] mat_len_log2,
  output logic             synced,
  output logic [CYC_W-1:0] cyc_idx
);
  logic [CYC_W-1:0] wrap_mask;
  assign wrap_mask = ~({CYC_W{1'b1}} << mat_len_log2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced  <= 1'b0;
      cyc_idx <= '0;
    end else if (ref_rx) begin
      if (!synced) begin
        synced  <= 1'b1;
        cyc_idx <= '0;
      end else begin
        cyc_idx <= (cyc_idx + 1'b1) & wrap_mask;
      end
    end
  end
endmodule

// File: rtl/tt_trigger_walk.sv
module tt_trigger_walk
  import ttsched_pkg::*;
#(
  parameter int N      = 4,
  parameter int TIME_W = 16,
  parameter int OBJ_W  = 3,
  parameter int CYC_W  = 3,
  localparam int IDX_W = $clog2(N),
  localparam int PTR_W = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv,
  input  logic [TIME_W-1:0] next_time,
  input  logic [CYC_W-1:0]  cyc_idx,
  input  logic              wdog,
  input  logic [TIME_W-1:0] e_mark [N],
  input  logic [1:0]        e_type [N],
  input  logic              e_dir  [N],
  input  logic [OBJ_W-1:0]  e_obj  [N],
  input  logic [CYC_W-1:0]  e_base [N],
  input  logic [REP_W-1:0]  e_rep  [N],
  output logic              mark_hit,
  output logic              fire_rx,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [OBJ_W-1:0]  cur_obj,
  output logic              tx_req,
  output logic              rx_chk,
  output logic [OBJ_W-1:0]  trig_obj,
  output logic              trig_arb
);
  logic [PTR_W-1:0] ptr_q;
  logic [N-1:0]     due;
  logic             ptr_ok, cur_live, fire_tx;

  for (genvar g = 0; g < N; g++) begin : g_due
    logic [CYC_W-1:0] rmask;
    assign rmask  = ~({CYC_W{1'b1}} << e_rep[g]);
    assign due[g] = ((cyc_idx & rmask) == (e_base[g] & rmask)) && !win_is_free(e_type[g]);
  end

  assign ptr_ok   = ptr_q < PTR_W'(N);
  assign cur_idx  = ptr_q[IDX_W-1:0];
  assign cur_obj  = e_obj[cur_idx];
  assign mark_hit = adv && ptr_ok && (next_time == e_mark[cur_idx]);
  assign cur_live = mark_hit && due[cur_idx];
  assign fire_tx  = cur_live && e_dir[cur_idx] && !wdog;
  assign fire_rx  = cur_live && !e_dir[cur_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      tx_req   <= 1'b0;
      rx_chk   <= 1'b0;
      trig_obj <= '0;
      trig_arb <= 1'b0;
    end else if (restart) begin
      ptr_q  <= '0;
      tx_req <= 1'b0;
      rx_chk <= 1'b0;
    end else begin
      tx_req <= fire_tx;
      rx_chk <= fire_rx;
      if (mark_hit) ptr_q <= ptr_q + 1'b1;
      if (fire_tx || fire_rx) begin
        trig_obj <= cur_obj;
        trig_arb <= (e_type[cur_idx] == WIN_ARB);
      end
    end
  end
endmodule

// File: rtl/tt_rx_monitor.sv
module tt_rx_monitor #(
  parameter int N     = 4,
  parameter int OBJ_W = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_rx,
  input  logic [IDX_W-1:0] fire_idx,
  input  logic [OBJ_W-1:0] fire_obj,
  input  logic             mark_hit,
  input  logic             restart,
  input  logic             rx_done,
  input  logic [OBJ_W-1:0] rx_obj,
  output logic [N-1:0]     miss_err
);
  logic             pend_q;
  logic [IDX_W-1:0] pend_idx;
  logic [OBJ_W-1:0] pend_obj;
  logic             arrived;

  assign arrived = pend_q && rx_done && (rx_obj == pend_obj);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pend_idx <= '0;
      pend_obj <= '0;
      miss_err <= '0;
    end else begin
      if (arrived) begin
        pend_q             <= 1'b0;
        miss_err[pend_idx] <= 1'b0;
      end else if (pend_q && (mark_hit || restart)) begin
        pend_q             <= 1'b0;
        miss_err[pend_idx] <= 1'b1;
      end
      if (fire_rx) begin
        pend_q   <= 1'b1;
        pend_idx <= fire_idx;
        pend_obj <= fire_obj;
      end
    end
  end
endmodule

// File: rtl/ttcan_window_sched.sv
module ttcan_window_sched
  import ttsched_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int TIME_W    = 16,
  parameter int OBJ_W     = 3,
  parameter int CYC_W     = 3,
  parameter int PRESC_W   = 8,
  localparam int LEN_W    = $clog2(CYC_W + 1),
  localparam int ENTRY_W  = TIME_W + 3 + OBJ_W + CYC_W + REP_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PRESC_W-1:0]           presc_div,
  input  logic [LEN_W-1:0]             mat_len_log2,
  input  logic [N_ENTRIES*ENTRY_W-1:0] cfg_table,
  input  logic                         ref_rx,
  input  logic                         rx_done,
  input  logic [OBJ_W-1:0]             rx_obj,
  output logic                         tx_req,
  output logic                         rx_chk,
  output logic [OBJ_W-1:0]             trig_obj,
  output logic                         trig_arb,
  output logic [CYC_W-1:0]             cyc_idx,
  output logic [TIME_W-1:0]            cyc_time,
  output logic                         wdog,
  output logic [N_ENTRIES-1:0]         miss_err
);
  localparam int IDX_W   = $clog2(N_ENTRIES);
  localparam int OFS_TY  = TIME_W;
  localparam int OFS_DIR = TIME_W + 2;
  localparam int OFS_OBJ = OFS_DIR + 1;
  localparam int OFS_BAS = OFS_OBJ + OBJ_W;
  localparam int OFS_REP = OFS_BAS + CYC_W;

  logic [TIME_W-1:0] e_mark [N_ENTRIES];
  logic [1:0]        e_type [N_ENTRIES];
  logic              e_dir  [N_ENTRIES];
  logic [OBJ_W-1:0]  e_obj  [N_ENTRIES];
  logic [CYC_W-1:0]  e_base [N_ENTRIES];
  logic [REP_W-1:0]  e_rep  [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_unpack
    assign e_mark[g] = cfg_table[g*ENTRY_W +: TIME_W];
    assign e_type[g] = cfg_table[g*ENTRY_W + OFS_TY +: 2];
    assign e_dir[g]  = cfg_table[g*ENTRY_W + OFS_DIR];
    assign e_obj[g]  = cfg_table[g*ENTRY_W + OFS_OBJ +: OBJ_W];
    assign e_base[g] = cfg_table[g*ENTRY_W + OFS_BAS +: CYC_W];
    assign e_rep[g]  = cfg_table[g*ENTRY_W + OFS_REP +: REP_W];
  end

  logic              synced, adv, mark_hit, fire_rx;
  logic [TIME_W-1:0] next_time;
  logic [IDX_W-1:0]  cur_idx;
  logic [OBJ_W-1:0]  cur_obj;

  tt_cycle_ctr #(.CYC_W(CYC_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .ref_rx(ref_rx), .mat_len_log2(mat_len_log2),
    .synced(synced), .cyc_idx(cyc_idx)
  );

  tt_timebase #(.TIME_W(TIME_W), .PRESC_W(PRESC_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(synced), .restart(ref_rx),
    .presc_div(presc_div), .ctime(cyc_time), .next_time(next_time),
    .adv(adv), .wdog(wdog)
  );

  tt_trigger_walk #(.N(N_ENTRIES), .TIME_W(TIME_W), .OBJ_W(OBJ_W), .CYC_W(CYC_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .restart(ref_rx), .adv(adv), .next_time(next_time),
    .cyc_idx(cyc_idx), .wdog(wdog),
    .e_mark(e_mark), .e_type(e_type), .e_dir(e_dir), .e_obj(e_obj),
    .e_base(e_base), .e_rep(e_rep),
    .mark_hit(mark_hit), .fire_rx(fire_rx), .cur_idx(cur_idx), .cur_obj(cur_obj),
    .tx_req(tx_req), .rx_chk(rx_chk), .trig_obj(trig_obj), .trig_arb(trig_arb)
  );

  tt_rx_monitor #(.N(N_ENTRIES), .OBJ_W(OBJ_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .fire_rx(fire_rx), .fire_idx(cur_idx),
    .fire_obj(cur_obj), .mark_hit(mark_hit), .restart(ref_rx),
    .rx_done(rx_done), .rx_obj(rx_obj), .miss_err(miss_err)
  );
endmodule

// File: rtl/ttcan_window_sched_chk.sv
module ttcan_window_sched_chk #(
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_rx,
  input logic              tx_req,
  input logic              rx_chk,
  input logic              wdog,
  input logic [TIME_W-1:0] cyc_time
);
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_req && rx_chk));

  a_r7_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req || rx_chk) |-> !$stable(cyc_time));

  a_r1_ref_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rx |=> (cyc_time == '0));

  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_rx |=> (cyc_time == $past(cyc_time) || cyc_time == $past(cyc_time) + 1'b1));

  a_r9_no_tx_in_wdog: assert property (@(posedge clk) disable iff (!rst_n)
    wdog |-> !tx_req);

  a_r9_wdog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wdog |=> wdog);
endmodule

bind ttcan_window_sched ttcan_window_sched_chk #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_rx(ref_rx), .tx_req(tx_req),
  .rx_chk(rx_chk), .wdog(wdog), .cyc_time(cyc_time)
);

// File: tb/ttcan_window_sched_tb.sv
`timescale 1ns/1ps
module ttcan_window_sched_tb;
  localparam int N = 4, EW = 27;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, ref_rx, rx_done, trig_arb, tx_req, rx_chk, wdog;
  logic [7:0]    presc_div;
  logic [1:0]    mat_len_log2;
  logic [N*EW-1:0] cfg_table;
  logic [2:0]    rx_obj, trig_obj, cyc_idx;
  logic [15:0]   cyc_time;
  logic [N-1:0]  miss_err;

  ttcan_window_sched u_dut (
    .clk(clk), .rst_n(rst_n), .presc_div(presc_div), .mat_len_log2(mat_len_log2),
    .cfg_table(cfg_table), .ref_rx(ref_rx), .rx_done(rx_done), .rx_obj(rx_obj),
    .tx_req(tx_req), .rx_chk(rx_chk), .trig_obj(trig_obj), .trig_arb(trig_arb),
    .cyc_idx(cyc_idx), .cyc_time(cyc_time), .wdog(wdog), .miss_err(miss_err)
  );

  int checks = 0, errors = 0;
  int bm[N], bt[N], bd[N], bo[N], bb[N], br[N];
  int P, mlog, cyc, synced_m, kk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg();
    for (int e = 0; e < N; e++)
      cfg_table[e*EW +: EW] = {br[e][1:0], bb[e][2:0], bo[e][2:0], bd[e][0], bt[e][1:0], bm[e][15:0]};
    presc_div    = P[7:0];
    mat_len_log2 = mlog[1:0];
  endtask

  task automatic set_entry(input int e, input int m, input int t, input int d, input int o);
    bm[e] = m; bt[e] = t; bd[e] = d; bo[e] = o; bb[e] = 0; br[e] = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_rx = 1'b0; rx_done = 1'b0; rx_obj = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    synced_m = 0; cyc = 0; kk = 0;
  endtask

  task automatic step();
    @(negedge clk);
    kk++;
  endtask

  task automatic send_ref();
    @(negedge clk); ref_rx = 1'b1;
    @(negedge clk); ref_rx = 1'b0;
    kk = 0;
    if (synced_m == 0) begin synced_m = 1; cyc = 0; end
    else cyc = (cyc + 1) % (1 << mlog);
  endtask

  function automatic bit due(input int e, input int c);
    int msk = (1 << br[e]) - 1;
    return (c & msk) == (bb[e] & msk);
  endfunction

  task automatic check_cycle();
    int et = 0, er = 0, eo = 0, ea = 0;
    string tag = "R1";
    for (int e = 0; e < N; e++) begin
      if (kk > 0 && kk == bm[e] * (P + 1)) begin
        if (bt[e] >= 2) tag = "R4";
        else if (!due(e, cyc)) tag = "R5";
        else if (bd[e] == 1) begin et = 1; tag = "R2"; end
        else begin er = 1; tag = "R3"; end
        eo = bo[e]; ea = (bt[e] == 1);
      end
    end
    chk({tag, " tx_req"}, tx_req, et);
    chk({tag, " rx_chk"}, rx_chk, er);
    chk("R7 one strobe", int'(tx_req) + int'(rx_chk) <= 1, 1);
    if (et || er) begin
      chk("R3 trig_obj", trig_obj, eo);
      chk("R4 trig_arb", trig_arb, ea);
    end
    chk("R1 cyc_time", cyc_time, kk / (P + 1));
    if (kk == 0) chk("R6 cyc_idx", cyc_idx, cyc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R10 reset state, then R1: no advance before a reference message
    P = 0; mlog = 0;
    set_entry(0, 1, 0, 1, 1); set_entry(1, 2, 0, 0, 2);
    set_entry(2, 3, 1, 1, 3); set_entry(3, 4, 2, 0, 4);
    apply_cfg();
    do_reset();
    chk("R10 tx_req", tx_req, 0);   chk("R10 rx_chk", rx_chk, 0);
    chk("R10 cyc_idx", cyc_idx, 0); chk("R10 cyc_time", cyc_time, 0);
    chk("R10 wdog", wdog, 0);       chk("R10 miss_err", miss_err, 0);
    for (int i = 0; i < 12; i++) begin
      step();
      chk("R1 idle cyc_time", cyc_time, 0);
      chk("R1 idle strobes", tx_req | rx_chk, 0);
    end

    // Random tables: R1..R7
    for (int it = 0; it < 8; it++) begin
      int m = 0;
      P = $urandom % 4; mlog = $urandom % 4;
      for (int e = 0; e < N; e++) begin
        m += 1 + ($urandom % 5);
        bm[e] = m; bt[e] = $urandom % 3; bd[e] = $urandom % 2; bo[e] = $urandom % 8;
        br[e] = $urandom % (mlog + 1); bb[e] = $urandom % (1 << br[e]);
      end
      apply_cfg();
      do_reset();
      for (int r = 0; r < (1 << mlog) + 2; r++) begin
        int len = (bm[N-1] + 2) * (P + 1) + ($urandom % 3);
        send_ref();
        for (int j = 0; j <= len; j++) begin
          check_cycle();
          step();
        end
      end
    end

    // R8 missing-message flags
    P = 1; mlog = 0;
    set_entry(0, 3, 0, 0, 2); set_entry(1, 6, 0, 1, 1);
    set_entry(2, 9, 0, 0, 5); set_entry(3, 12, 2, 0, 0);
    apply_cfg();
    do_reset();
    send_ref();
    while (kk < 8) step();
    rx_done = 1'b1; rx_obj = 3'd2;
    step();
    rx_done = 1'b0;
    while (kk < 23) step();
    chk("R8 before next mark", miss_err, 4'b0000);
    step();
    chk("R8 miss at next mark", miss_err, 4'b0100);
    step(); step();
    chk("R8 flag holds", miss_err, 4'b0100);
    send_ref();
    while (kk < 20) step();
    rx_done = 1'b1; rx_obj = 3'd5;
    step();
    rx_done = 1'b0;
    while (kk < 26) step();
    chk("R8 clear and new miss", miss_err, 4'b0001);

    // R9 watchdog
    P = 0; mlog = 0;
    set_entry(0, 3, 0, 1, 6); set_entry(1, 4, 0, 0, 7);
    set_entry(2, 5, 2, 0, 0); set_entry(3, 6, 2, 0, 0);
    apply_cfg();
    do_reset();
    send_ref();
    while (kk < 65535) step();
    chk("R9 wdog before overrun", wdog, 0);
    chk("R9 cyc_time at max", cyc_time, 65535);
    step();
    chk("R9 wdog on overrun", wdog, 1);
    chk("R9 cyc_time held", cyc_time, 65535);
    send_ref();
    while (kk < 3) step();
    chk("R9 tx inhibited", tx_req, 0);
    chk("R9 cyc_time restarted", cyc_time, 3);
    step();
    chk("R9 rx still checked", rx_chk, 1);
    chk("R9 wdog sticky", wdog, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule